// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block performs the data operations of a small 8-bit processor core. Two operands arrive from the surrounding datapath. The base operand feeds every operation, and the other operand is used only by binary operations. A 3-bit code chooses the base operation. A separate bit inverts the outcome, which gives the NOR, NAND and XNOR forms and inverted sums.

The result is combinational. A status register holds six flags: sign, zero, carry, interrupt disable, decimal and break. When the caller marks an operation valid, the register captures the sign, zero and carry that the operation produces. The carry and decimal bits feed back into the next operation, which allows chained multi-byte arithmetic and decimal arithmetic on packed two-digit BCD values.

A compare mode evaluates the two operands as unsigned values and updates only the flags. Its result port simply shows the base operand. The caller can also load the whole flag set from outside, for example when the flags are restored from the stack.

Top module: `alu_flag_unit`

## Requirements
- R1: Asserting `rst_n` low sets `status` to 0x10 at once: interrupt disable set, every other bit clear. After release the register stays in reset for two more clock edges.
- R2: `op_sel` encodings are 0 pass, 1 shift left, 2 shift right, 3 add, 4 subtract, 5 OR, 6 AND and 7 XOR. `result` follows the inputs combinationally. Pass and the shifts ignore `sec`.
- R3: With `inv_en` high, `result` is the bitwise inverse of the selected operation's value, so OR, AND and XOR become NOR, NAND and XNOR.
- R4: In binary mode, add gives prim+sec+C and subtract gives prim-sec-(1-C). C takes the carry out. After a subtract, C=1 means no borrow occurred.
- R5: When D (status bit 3) is set, add and subtract treat each nibble as a decimal digit and return a BCD result. C is the decimal carry, or the inverse of the decimal borrow.
- R6: A shift moves the bit shifted out into C. The vacated bit is filled with the old C when `rot_en` is high, and with 0 otherwise.
- R7: Pass and the logic operations leave C unchanged.
- R8: On a valid non-compare operation, S takes `result` bit 7 and Z is set when `result` is zero. Both are taken after inversion.
- R9: With `cmp_en` high, a valid operation ignores `op_sel` and `inv_en`. It sets Z when prim equals sec, S when prim is less than sec and C when prim is greater than or equal to sec, all unsigned. `result` shows prim.
- R10: The status layout is S bit 7, Z bit 6, C bit 5, I bit 4, D bit 3 and K bit 2. Bits 1:0 always read 0. `p_load` copies `flag_din` (S down to K) into bits 7:2 and takes priority over `op_valid`.
- R11: A valid operation clears K and keeps I and D. With neither `op_valid` nor `p_load` high, `status` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commit this cycle's flags to the status register |
| op_sel | input | 3 | Operation code |
| inv_en | input | 1 | Invert the operation's value |
| rot_en | input | 1 | Shifts fill the vacated bit with carry |
| cmp_en | input | 1 | Compare mode: flags only |
| prim | input | DW (8) | Base operand |
| sec | input | DW (8) | Second operand |
| p_load | input | 1 | Load the flags from `flag_din` |
| flag_din | input | 6 | New S, Z, C, I, D, K (MSB first) |
| result | output | DW (8) | Operation result |
| status | output | 8 | Status register |

## Verification
Each operation is applied with the carry preset both ways. This separates carry-in use from a plain sum and separates rotates from plain shifts. Operand pairs are chosen so that the sign, zero and carry flags each come out both set and clear.

Decimal vectors force a digit carry or borrow in the low nibble, the high nibble and both, which a binary adder cannot imitate. Compare vectors use an operand with bit 7 set that is still greater than the other operand, so that the compare sign flag cannot be confused with result bit 7. Directed steps cover a load issued in the same cycle as an operation, idle cycles with busy inputs, and a reset in the middle of a run.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_SHL  = 3'd1,
    OP_SHR  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_OR   = 3'd5,
    OP_AND  = 3'd6,
    OP_XOR  = 3'd7
  } alu_op_e;

  localparam int FLG_S = 7;
  localparam int FLG_Z = 6;
  localparam int FLG_C = 5;
  localparam int FLG_I = 4;
  localparam int FLG_D = 3;
  localparam int FLG_K = 2;

  localparam logic [7:0] STATUS_RST = 8'h10;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  input  logic         dec,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0]   bin_wide;
  logic [W-1:0] bcd_sum;
  logic         bcd_cout;

  // binary path: subtract is a + ~b + carry (carry = no borrow)
  assign bin_wide = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, cin};

  // decimal path: one digit per step, carry/borrow rippling upward
  always_comb begin
    logic       link;
    logic [4:0] t;
    bcd_sum = '0;
    link    = sub ? ~cin : cin;
    for (int i = 0; i < DIGITS; i++) begin
      if (sub) begin
        t = {1'b0, a[4*i +: 4]} - {1'b0, b[4*i +: 4]} - {4'b0, link};
        if (t[4]) begin
          t    = t + 5'd10;
          link = 1'b1;
        end else begin
          link = 1'b0;
        end
      end else begin
        t = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, link};
        if (t > 5'd9) begin
          t    = t + 5'd6;
          link = 1'b1;
        end else begin
          link = 1'b0;
        end
      end
      bcd_sum[4*i +: 4] = t[3:0];
    end
    bcd_cout = sub ? ~link : link;
  end

  assign sum  = dec ? bcd_sum  : bin_wide[W-1:0];
  assign cout = dec ? bcd_cout : bin_wide[W];
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift import alu_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         rot,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         c_upd
);
  logic fill;
  assign fill = rot & cin;

  always_comb begin
    res   = a;
    cout  = cin;
    c_upd = 1'b0;
    unique case (op)
      OP_SHL: begin
        res   = {a[W-2:0], fill};
        cout  = a[W-1];
        c_upd = 1'b1;
      end
      OP_SHR: begin
        res   = {fill, a[W-1:1]};
        cout  = a[0];
        c_upd = 1'b1;
      end
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg import alu_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [5:0] din,
  input  logic       upd,
  input  logic       s_new,
  input  logic       z_new,
  input  logic       c_new,
  output logic [7:0] status
);
  localparam int LSB = FLG_K;

  logic [7:LSB] flags_q, flags_d;
  logic         flags_en;

  always_comb begin
    flags_d = flags_q;
    if (ld) begin
      flags_d = din;
    end else if (upd) begin
      flags_d[FLG_S] = s_new;
      flags_d[FLG_Z] = z_new;
      flags_d[FLG_C] = c_new;
      flags_d[FLG_K] = 1'b0;
    end
  end

  assign flags_en = ld | upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= STATUS_RST[7:LSB];
    else if (flags_en) flags_q <= flags_d;
  end

  assign status = {flags_q, {LSB{1'b0}}};
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit import alu_pkg::*; #(
  parameter int DIGITS = 2,
  localparam int DW = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_sel,
  input  logic          inv_en,
  input  logic          rot_en,
  input  logic          cmp_en,
  input  logic [DW-1:0] prim,
  input  logic [DW-1:0] sec,
  input  logic          p_load,
  input  logic [5:0]    flag_din,
  output logic [DW-1:0] result,
  output logic [7:0]    status
);
  alu_op_e       op;
  logic          rst_sync_n;
  logic          c_cur, d_cur;
  logic [DW-1:0] ar_sum, ls_res, base, final_val;
  logic          ar_cout, ls_cout, ls_cupd;
  logic          is_arith, c_base, c_upd;
  logic          s_new, z_new, c_new, lt;

  assign op    = alu_op_e'(op_sel);
  assign c_cur = status[FLG_C];
  assign d_cur = status[FLG_D];

  alu_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  alu_arith #(.DIGITS(DIGITS)) u_arith (
    .a   (prim),
    .b   (sec),
    .cin (c_cur),
    .sub (op == OP_SUB),
    .dec (d_cur),
    .sum (ar_sum),
    .cout(ar_cout)
  );

  alu_logic_shift #(.W(DW)) u_ls (
    .a    (prim),
    .b    (sec),
    .op   (op),
    .rot  (rot_en),
    .cin  (c_cur),
    .res  (ls_res),
    .cout (ls_cout),
    .c_upd(ls_cupd)
  );

  assign is_arith  = (op == OP_ADD) || (op == OP_SUB);
  assign base      = is_arith ? ar_sum  : ls_res;
  assign c_base    = is_arith ? ar_cout : ls_cout;
  assign c_upd     = is_arith | ls_cupd;
  assign final_val = inv_en ? ~base : base;
  assign lt        = prim < sec;

  always_comb begin
    if (cmp_en) begin
      result = prim;
      s_new  = lt;
      z_new  = (prim == sec);
      c_new  = ~lt;
    end else begin
      result = final_val;
      s_new  = final_val[DW-1];
      z_new  = (final_val == '0);
      c_new  = c_upd ? c_base : c_cur;
    end
  end

  alu_status_reg u_status (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (p_load),
    .din   (flag_din),
    .upd   (op_valid),
    .s_new (s_new),
    .z_new (z_new),
    .c_new (c_new),
    .status(status)
  );
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_q,
  input logic          op_valid,
  input logic          cmp_en,
  input logic          p_load,
  input logic [DW-1:0] prim,
  input logic [DW-1:0] sec,
  input logic [5:0]    flag_din,
  input logic [DW-1:0] result,
  input logic [7:0]    status
);
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_q)
    status[1:0] == 2'b00); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_q)
    p_load |=> status[7:2] == $past(flag_din)); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    (!op_valid && !p_load) |=> $stable(status)); // R11

  AST_K_CLEARED: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !p_load) |=> !status[2]); // R11

  AST_ID_KEPT: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !p_load) |=> status[4:3] == $past(status[4:3])); // R11

  AST_SZ_TRACK: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !p_load && !cmp_en) |=>
      (status[7] == $past(result[DW-1])) && (status[6] == ($past(result) == '0))); // R8

  AST_CMP_FLAGS: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && !p_load && cmp_en) |=>
      (status[6] == ($past(prim) == $past(sec))) &&
      (status[5] == ($past(prim) >= $past(sec))) &&
      (status[7] == ($past(prim) <  $past(sec)))); // R9

  AST_CMP_RESULT: assert property (@(posedge clk) disable iff (!rst_q)
    cmp_en |-> result == prim); // R9
endmodule

bind alu_flag_unit alu_flag_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_q   (rst_sync_n),
  .op_valid(op_valid),
  .cmp_en  (cmp_en),
  .p_load  (p_load),
  .prim    (prim),
  .sec     (sec),
  .flag_din(flag_din),
  .result  (result),
  .status  (status)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, inv_en, rot_en, cmp_en, p_load;
  logic [2:0] op_sel;
  logic [7:0] prim, sec, result, status;
  logic [5:0] flag_din;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .inv_en(inv_en), .rot_en(rot_en), .cmp_en(cmp_en), .prim(prim),
    .sec(sec), .p_load(p_load), .flag_din(flag_din),
    .result(result), .status(status)
  );

  // {op, inv, rot, cmp, prim, sec, preset status, expected result, expected status}
  localparam logic [45:0] VEC [28] = '{
    {3'd0,1'b0,1'b0,1'b0,8'h80,8'h55,8'h20,8'h80,8'hA0},
    {3'd0,1'b1,1'b0,1'b0,8'hFF,8'h00,8'h04,8'h00,8'h40},
    {3'd1,1'b0,1'b0,1'b0,8'h81,8'h00,8'h20,8'h02,8'h20},
    {3'd1,1'b0,1'b1,1'b0,8'h40,8'h00,8'h20,8'h81,8'h80},
    {3'd2,1'b0,1'b0,1'b0,8'h01,8'hFF,8'h00,8'h00,8'h60},
    {3'd2,1'b0,1'b1,1'b0,8'h02,8'h00,8'h20,8'h81,8'h80},
    {3'd3,1'b0,1'b0,1'b0,8'h7F,8'h01,8'h00,8'h80,8'h80},
    {3'd3,1'b0,1'b0,1'b0,8'hFF,8'h01,8'h20,8'h01,8'h20},
    {3'd4,1'b0,1'b0,1'b0,8'h05,8'h03,8'h20,8'h02,8'h20},
    {3'd4,1'b0,1'b0,1'b0,8'h03,8'h05,8'h20,8'hFE,8'h80},
    {3'd4,1'b0,1'b0,1'b0,8'h05,8'h05,8'h00,8'hFF,8'h80},
    {3'd5,1'b0,1'b0,1'b0,8'hF0,8'h0F,8'h20,8'hFF,8'hA0},
    {3'd5,1'b1,1'b0,1'b0,8'hF0,8'h0F,8'h00,8'h00,8'h40},
    {3'd6,1'b0,1'b0,1'b0,8'hF0,8'h3C,8'h00,8'h30,8'h00},
    {3'd6,1'b1,1'b0,1'b0,8'hFF,8'hFF,8'h10,8'h00,8'h50},
    {3'd7,1'b0,1'b0,1'b0,8'hAA,8'h55,8'h00,8'hFF,8'h80},
    {3'd7,1'b1,1'b0,1'b0,8'hAA,8'hAA,8'h20,8'hFF,8'hA0},
    {3'd3,1'b1,1'b0,1'b0,8'h01,8'h01,8'h00,8'hFD,8'h80},
    {3'd3,1'b0,1'b0,1'b0,8'h45,8'h38,8'h08,8'h83,8'h88},
    {3'd3,1'b0,1'b0,1'b0,8'h99,8'h01,8'h08,8'h00,8'h68},
    {3'd3,1'b0,1'b0,1'b0,8'h58,8'h46,8'h28,8'h05,8'h28},
    {3'd4,1'b0,1'b0,1'b0,8'h42,8'h17,8'h28,8'h25,8'h28},
    {3'd4,1'b0,1'b0,1'b0,8'h10,8'h20,8'h28,8'h90,8'h88},
    {3'd4,1'b0,1'b0,1'b0,8'h50,8'h01,8'h08,8'h48,8'h28},
    {3'd3,1'b0,1'b0,1'b1,8'h30,8'h30,8'h00,8'h30,8'h60},
    {3'd3,1'b1,1'b0,1'b1,8'h10,8'h20,8'h14,8'h10,8'h90},
    {3'd0,1'b0,1'b0,1'b1,8'h90,8'h20,8'h00,8'h90,8'h20},
    {3'd0,1'b0,1'b0,1'b0,8'h00,8'h77,8'h08,8'h00,8'h48}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic string class_tag(input logic [45:0] v, input bit for_res);
    logic [2:0] op;
    op = v[45:43];
    if (v[40])                    return "R9";
    if (for_res && v[42])         return "R3";
    if (op == 3'd3 || op == 3'd4) return v[19] ? "R5" : "R4";
    if (op == 3'd1 || op == 3'd2) return "R6";
    return for_res ? "R2" : "R7";
  endfunction

  task automatic run_vec(input logic [45:0] v);
    @(negedge clk);
    op_valid = 1'b0; p_load = 1'b1; flag_din = v[23:18];
    @(negedge clk);
    p_load = 1'b0;
    op_sel = v[45:43]; inv_en = v[42]; rot_en = v[41]; cmp_en = v[40];
    prim = v[39:32]; sec = v[31:24]; op_valid = 1'b1;
    #1 chk(class_tag(v, 1'b1), result, v[15:8]);
    @(negedge clk);
    op_valid = 1'b0;
    chk({class_tag(v, 1'b0), " R8"}, status, v[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; p_load = 1'b0; op_sel = 3'd0;
    inv_en = 1'b0; rot_en = 1'b0; cmp_en = 1'b0;
    prim = 8'h00; sec = 8'h00; flag_din = 6'h00;
    repeat (2) @(negedge clk);
    chk("R1 reset value", status, 8'h10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", status, 8'h10);

    for (int i = 0; i < 28; i++) run_vec(VEC[i]);

    // R10: load beats a simultaneous operation, low bits read 0
    @(negedge clk);
    p_load = 1'b1; flag_din = 6'h3F; op_valid = 1'b1;
    op_sel = 3'd3; inv_en = 1'b0; rot_en = 1'b0; cmp_en = 1'b0; prim = 8'h00; sec = 8'h00;
    @(negedge clk);
    p_load = 1'b0; op_valid = 1'b0;
    chk("R10 load priority", status, 8'hFC);

    // R11: idle cycles with busy inputs keep the flags
    for (int k = 0; k < 3; k++) begin
      prim = 8'h11 * k[7:0]; sec = 8'hF0; op_sel = 3'(k + 3);
      @(negedge clk);
    end
    chk("R11 hold", status, 8'hFC);

    // R11: operation clears K, keeps I and D, pass keeps C
    op_sel = 3'd0; prim = 8'h01; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11 K clear I D kept", status, 8'h38);

    // R2: unary ops ignore the second operand
    op_sel = 3'd0; prim = 8'h3C; sec = 8'h00;
    #1 chk("R2 pass sec 00", result, 8'h3C);
    sec = 8'hFF;
    #1 chk("R2 pass sec FF", result, 8'h3C);
    op_sel = 3'd2; rot_en = 1'b0;
    #1 chk("R2 shift sec FF", result, 8'h1E);

    // R1: reset in mid-run acts at once
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async reset", status, 8'h10);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post reset", status, 8'h10);

    finish_run();
  end
endmodule